// File: doc/BRIEF.md
# Timing-Error Cycle Suppression Controller

This block paces a pipeline whose critical-path registers can report late data. It runs from a fast reference clock and divides it into pipeline periods of `PERIOD` ticks. From that division it builds two timing outputs. The first is a local clock enable, high for the first half of each period. The second is a watch strobe, which is high at the start of the period and falls `WATCH_DLY` ticks after the period begins. Late transitions are only looked for while the strobe is low. The distance from its falling edge to the next period start is the detection window. A longer window catches more late arrivals, but it also flags more transitions that were in fact legitimate.

Every monitored register drives an active-low error line, and the controller ORs all of these lines together. If an error is seen inside the watch window of a period that was delivered, the decision is taken before that period ends, and the whole next period has its local clock enable held low. This single dropped pulse gives the late data one extra period to settle. Nothing is rolled back or replayed. Three saturating counters make the clock behaviour visible: delivered periods, suppressed periods, and error ticks that arrived while the strobe was still high.

Top module: `cycle_skip_ctl`

## Requirements
- R1: While reset is asserted, the outputs are as follows: `lclk_en_o`=1, `ctl_o`=1 and all three counters are 0. The first tick after reset release is tick 0 of a period.
- R2: In each period, `ctl_o` is 1 on ticks 0..WATCH_DLY-1 and 0 on ticks WATCH_DLY..PERIOD-1. This holds whether or not the period is suppressed.
- R3: In a delivered period, `lclk_en_o` is 1 on ticks 0..PERIOD/2-1 and 0 on the remaining ticks.
- R4: Suppose any `err_n` bit is 0 on a tick where `ctl_o` is 0, during a delivered period. Then `lclk_en_o` stays 0 for every tick of the next period. If no further error occurs, the period after that is delivered.
- R5: An error that is present only on ticks where `ctl_o` is 1 never causes a suppressed period.
- R6: Errors seen during a suppressed period are ignored for suppression, so the period that follows it is delivered.
- R7: All error lines are merged with OR. A low level on any single line causes suppression, and so does a low level on several lines together. This includes an error on the last tick (PERIOD-1) of a period.
- R8: At the end of each period, `deliv_cnt_o` increments if the period was delivered and `skip_cnt_o` increments if it was suppressed. The new value is visible from tick 0 of the next period. Both counters stop at all-ones.
- R9: `false_cnt_o` increments by one for each tick on which any error line is 0 while `ctl_o` is 1. It stops at all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| err_n | input | NUM_REG | Active-low late-arrival flags, one per monitored register |
| lclk_en_o | output | 1 | Local pipeline clock enable |
| ctl_o | output | 1 | Watch strobe; errors are sampled while it is low |
| deliv_cnt_o | output | CNT_W | Delivered-period counter, saturating |
| skip_cnt_o | output | CNT_W | Suppressed-period counter, saturating |
| false_cnt_o | output | CNT_W | Error ticks outside the watch window, saturating |

## Verification
The bench builds the block with PERIOD=8, WATCH_DLY=5, NUM_REG=3 and CNT_W=4. With an 8-tick period there are three watch ticks per period, so errors can be placed at the first watch tick, at the last tick, and on strobe-high ticks. Three error lines are enough to exercise the OR merge one line at a time and with several lines together. A 4-bit counter width lets all three counters reach saturation within a few dozen periods.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // Decoded position inside one pipeline period
  typedef struct packed {
    logic lclk_ph;  // first half of the period
    logic watch;    // detection window open (strobe low)
    logic wrap;     // last tick of the period
  } cs_phase_t;
endpackage

// File: rtl/cs_phase_gen.sv
module cs_phase_gen
  import cs_pkg::*;
#(
  parameter int PERIOD    = 8,
  parameter int WATCH_DLY = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  output cs_phase_t phase_o
);
  localparam int PW = $clog2(PERIOD);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] HALF = PW'(PERIOD / 2);
  localparam logic [PW-1:0] FALL = PW'(WATCH_DLY);

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    if (ph_q == LAST) ph_d = '0;
    else              ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  always_comb begin
    phase_o.lclk_ph = (ph_q < HALF);
    phase_o.watch   = (ph_q >= FALL);
    phase_o.wrap    = (ph_q == LAST);
  end
endmodule

// File: rtl/cs_err_judge.sv
module cs_err_judge
  import cs_pkg::*;
#(
  parameter int NUM_REG = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REG-1:0] err_n,
  input  cs_phase_t          phase_i,
  output logic               supp_o,
  output logic               early_hit_o
);
  logic err_any;
  logic hit;
  logic pend_q, pend_d;
  logic supp_q, supp_d;

  // OR merge of active-low flags
  assign err_any = |(~err_n);
  // only a delivered period can arm a suppression
  assign hit     = err_any & phase_i.watch & ~supp_q;

  always_comb begin
    pend_d = pend_q | hit;
    supp_d = supp_q;
    if (phase_i.wrap) begin
      pend_d = 1'b0;
      supp_d = pend_q | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      supp_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      supp_q <= supp_d;
    end
  end

  assign supp_o      = supp_q;
  assign early_hit_o = err_any & ~phase_i.watch;
endmodule

// File: rtl/cs_sat_cnt.sv
module cs_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  assign en    = inc_i & (cnt_q != '1);
  assign cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cycle_skip_ctl.sv
module cycle_skip_ctl
  import cs_pkg::*;
#(
  parameter int PERIOD    = 8,
  parameter int WATCH_DLY = 5,
  parameter int NUM_REG   = 8,
  parameter int CNT_W     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REG-1:0] err_n,
  output logic               lclk_en_o,
  output logic               ctl_o,
  output logic [CNT_W-1:0]   deliv_cnt_o,
  output logic [CNT_W-1:0]   skip_cnt_o,
  output logic [CNT_W-1:0]   false_cnt_o
);
  localparam int NCNT = 3;

  cs_phase_t          phase;
  logic               supp;
  logic               early_hit;
  logic               wrap_w;
  logic [NCNT-1:0]    inc;
  logic [CNT_W-1:0]   cnt [NCNT];

  cs_phase_gen #(.PERIOD(PERIOD), .WATCH_DLY(WATCH_DLY)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_o (phase)
  );

  cs_err_judge #(.NUM_REG(NUM_REG)) u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_n       (err_n),
    .phase_i     (phase),
    .supp_o      (supp),
    .early_hit_o (early_hit)
  );

  assign wrap_w = phase.wrap;
  assign inc[0] = phase.wrap & ~supp;  // delivered
  assign inc[1] = phase.wrap &  supp;  // suppressed
  assign inc[2] = early_hit;           // outside window

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    cs_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (inc[g]),
      .cnt_o (cnt[g])
    );
  end

  assign lclk_en_o   = phase.lclk_ph & ~supp;
  assign ctl_o       = ~phase.watch;
  assign deliv_cnt_o = cnt[0];
  assign skip_cnt_o  = cnt[1];
  assign false_cnt_o = cnt[2];
endmodule

// File: rtl/cycle_skip_chk.sv
module cycle_skip_chk #(
  parameter int NUM_REG = 8,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REG-1:0] err_n,
  input logic               lclk_en_o,
  input logic               ctl_o,
  input logic [CNT_W-1:0]   deliv_cnt_o,
  input logic [CNT_W-1:0]   skip_cnt_o,
  input logic [CNT_W-1:0]   false_cnt_o,
  input logic               wrap,
  input logic               supp
);
  // period start: strobe rises with the clock enable unless suppressed
  p_ctl_rise_with_lclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_o) |-> (lclk_en_o || supp));

  p_err_arms_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ctl_o && !supp && (err_n != '1)) |=> supp);

  p_no_extend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && supp) |=> !supp);

  p_skip_no_lclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    supp |-> !lclk_en_o);

  p_deliv_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(deliv_cnt_o) && $stable(skip_cnt_o));

  p_deliv_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (deliv_cnt_o == '1) |=> (deliv_cnt_o == '1));

  p_false_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (false_cnt_o == '1) |=> (false_cnt_o == '1));

  p_false_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_n == '1) |=> $stable(false_cnt_o));
endmodule

bind cycle_skip_ctl cycle_skip_chk #(.NUM_REG(NUM_REG), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_n       (err_n),
  .lclk_en_o   (lclk_en_o),
  .ctl_o       (ctl_o),
  .deliv_cnt_o (deliv_cnt_o),
  .skip_cnt_o  (skip_cnt_o),
  .false_cnt_o (false_cnt_o),
  .wrap        (wrap_w),
  .supp        (supp)
);

// File: tb/cycle_skip_ctl_bench.sv
module cycle_skip_ctl_bench;
  localparam int PER = 8;
  localparam int DLY = 5;
  localparam int NR  = 3;
  localparam int CW  = 4;
  localparam logic [CW-1:0] MAXC = '1;

  typedef struct packed {
    logic          lclk;
    logic          ctl;
    logic [CW-1:0] dv;
    logic [CW-1:0] sk;
    logic [CW-1:0] fa;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] err_n = '1;
  logic          lclk_en_o, ctl_o;
  logic [CW-1:0] deliv_cnt_o, skip_cnt_o, false_cnt_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  item_t q[$];

  // reference model state
  int            t = 0;
  logic          m_supp = 0, m_pend = 0;
  logic [CW-1:0] m_dv = 0, m_sk = 0, m_fa = 0;

  always #2.5 clk = ~clk;

  cycle_skip_ctl #(.PERIOD(PER), .WATCH_DLY(DLY), .NUM_REG(NR), .CNT_W(CW)) u_cycle_skip_ctl (
    .clk(clk), .rst_n(rst_n), .err_n(err_n), .lclk_en_o(lclk_en_o), .ctl_o(ctl_o),
    .deliv_cnt_o(deliv_cnt_o), .skip_cnt_o(skip_cnt_o), .false_cnt_o(false_cnt_o));

  task automatic cmp(input logic [CW-1:0] act, input logic [CW-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // monitor: pops expected items and compares with outputs
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      cmp(CW'(lclk_en_o), CW'(e.lclk), "R1/R3/R4 lclk_en_o");
      cmp(CW'(ctl_o), CW'(e.ctl), "R1/R2 ctl_o");
      cmp(deliv_cnt_o, e.dv, "R8 deliv_cnt_o");
      cmp(skip_cnt_o, e.sk, "R8 skip_cnt_o");
      cmp(false_cnt_o, e.fa, "R9 false_cnt_o");
    end
  end

  // driver: one reference tick, current negedge
  task automatic tick(input logic [NR-1:0] mask);
    item_t e;
    logic  any;
    err_n  = ~mask;
    e.lclk = (t < PER / 2) && !m_supp;
    e.ctl  = (t < DLY);
    e.dv   = m_dv;
    e.sk   = m_sk;
    e.fa   = m_fa;
    q.push_back(e);
    any = |mask;
    if (t < DLY && any && m_fa != MAXC) m_fa++;
    if (t >= DLY && any && !m_supp) m_pend = 1;
    if (t == PER - 1) begin
      if (m_supp) begin if (m_sk != MAXC) m_sk++; end
      else        begin if (m_dv != MAXC) m_dv++; end
      m_supp = m_pend;
      m_pend = 0;
    end
    t = (t + 1) % PER;
    @(negedge clk);
  endtask

  task automatic run_period(input int lo, input int hi, input logic [NR-1:0] mask);
    for (int k = 0; k < PER; k++) tick((k >= lo && k <= hi) ? mask : '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset values
    q.push_back('{lclk: 1'b1, ctl: 1'b1, dv: '0, sk: '0, fa: '0});
    @(negedge clk);
    rst_n = 1'b1;
    run_period(-1, -1, '0);            // R3 idle
    run_period(-1, -1, '0);
    run_period(DLY, DLY, 3'b001);      // R4 line 0, first watch tick
    run_period(6, 6, 3'b010);          // R6 error during suppressed period
    run_period(-1, -1, '0);            // R6 delivered
    run_period(0, DLY - 1, 3'b100);    // R5 strobe-high errors, R9 counted
    run_period(-1, -1, '0);
    run_period(PER - 1, PER - 1, 3'b100); // R7 last tick, line 2
    run_period(-1, -1, '0);
    run_period(DLY, PER - 1, 3'b111);  // R7 all lines together
    run_period(-1, -1, '0);
    for (int p = 0; p < 3; p++) run_period(0, DLY - 1, 3'b010); // R9 saturation
    for (int p = 0; p < 16; p++) run_period(-1, -1, '0);        // R8 saturation
    for (int p = 0; p < 4; p++) begin                           // R8 skip saturation
      run_period(DLY, DLY, 3'b001);
      run_period(-1, -1, '0);
    end
    for (int p = 0; p < 12; p++) begin
      run_period(DLY + 1, DLY + 1, 3'b010);
      run_period(-1, -1, '0);
    end
    @(negedge clk);
    #3;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end
endmodule